// File: doc/BRIEF.md
# Ramp Sequencer with Blanking

This block produces the digital code word for a ramp DAC and a matching blanking flag. A 12-bit counter moves forward one step on each cycle where the tick enable is high. For the first 4000 counter states the counter value goes straight to the code output, which gives a linear staircase ramp. For the last 96 states of the 4096-state cycle, the code is forced to zero and the blanking flag is raised. This gives the driven equipment a fixed, clock-accurate interval in which to return to its start point. With a 40 kHz tick, one 4000-step ramp lasts exactly 100 ms.

A mode pin selects between two ways of running. In free-running mode the counter wraps without stopping. In triggered mode the sequencer parks as soon as blanking begins: the counter is held at zero, the code stays at zero and the blanking flag stays high. It stays parked until a rising edge arrives on the external trigger pin. The trigger pin is asynchronous, so it passes through a two-flop synchroniser before its edge is detected.

The code output and the blanking flag are levels that are sampled all the time. They are not a stream of transfers, so the block has no valid/ready handshake. Every pin is a plain control or status level.

Top module: `ramp_seq`

## Requirements
- R1: When synchronous reset is applied, the counter returns to zero and the park latch clears, so `dac_code` reads 0 and `blank` reads 0.
- R2: While the sequencer is not parked and the count is between 0 and 3999, `dac_code` equals the count.
- R3: For counts 4000 to 4095, `dac_code` is all zeros. In free-running mode, exactly 96 of any 4096 consecutive tick positions are blanked.
- R4: `blank` is 1 exactly when the code is forced to zero (blanking window or parked). It is 0 during the ramp.
- R5: With `trig_mode` = 0 (free-running), the count rises by one on each rising clock edge where `tick_en` is 1, and it wraps from 4095 to 0.
- R6: On a clock edge where `tick_en` is 0, the count does not change (unless R11 applies).
- R7: With `trig_mode` = 1 (triggered), a tick at count 3999 parks the sequencer instead of entering count 4000. While parked, the count is 0, `dac_code` is 0 and `blank` is 1, whatever ticks arrive.
- R8: While parked, a 0-to-1 change on `trig_in` releases the sequencer. `blank` falls after the third rising clock edge, counting from the first edge that samples `trig_in` high. Counting then restarts from zero, so the first tick afterwards gives `dac_code` = 1.
- R9: Rising edges on `trig_in` while the sequencer is not parked have no effect on the count or the outputs.
- R10: Driving `trig_mode` to 0 while parked releases the sequencer at the next clock edge, with the count at zero.
- R11: Driving `trig_mode` to 1 while the count is inside the blanking window parks the sequencer at the next clock edge, with or without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count enable; one step per high cycle |
| trig_mode | input | 1 | 0 = free-running, 1 = triggered |
| trig_in | input | 1 | Asynchronous external trigger |
| dac_code | output | 12 | Code word for the ramp DAC |
| blank | output | 1 | High during blanking or while parked |

## Verification
The count, the park latch and both outputs all change on the rising edge that samples the tick or the mode. No further register lies between the counter and the pins, so every result is due one edge after its stimulus. The only exception is trigger release, which takes three edges: two synchroniser stages, then the park latch. The bench drives inputs on the falling edge and advances its reference model once per rising edge. It compares both outputs on the following falling edge, and at the release it checks the flag after edges one, two and three one at a time.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  localparam int unsigned RS_CNT_W       = 12;
  localparam int unsigned RS_RAMP_LEN    = 4000;
  localparam int unsigned RS_SYNC_STAGES = 2;

  typedef enum logic {
    SWEEP_FREE = 1'b0,
    SWEEP_TRIG = 1'b1
  } sweep_mode_e;
endpackage

// File: rtl/ramp_trig_sync.sv
module ramp_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic edge_o
);
  // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], trig_in};
  end

  assign edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R8
  trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ramp_count_core.sv
module ramp_count_core
  import ramp_seq_pkg::*;
#(
  parameter int unsigned CNT_W    = RS_CNT_W,
  parameter int unsigned RAMP_LEN = RS_RAMP_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             mode_i,
  input  logic             rel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hold_o
);
  localparam logic [CNT_W-1:0] LAST_RAMP   = CNT_W'(RAMP_LEN - 1);
  localparam logic [CNT_W-1:0] BLANK_START = CNT_W'(RAMP_LEN);
  localparam logic [CNT_W-1:0] CNT_TOP     = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             trig_m, in_blank, park_now;

  assign trig_m   = (sweep_mode_e'(mode_i) == SWEEP_TRIG);
  assign in_blank = (cnt_q >= BLANK_START);
  assign park_now = trig_m && (in_blank || (tick_i && cnt_q == LAST_RAMP));

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (hold_q) begin
      cnt_d = '0;
      if (!trig_m || rel_i) hold_d = 1'b0;
    end else if (park_now) begin
      cnt_d  = '0;
      hold_d = 1'b1;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;

  // R6
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !tick_i && !(trig_m && in_blank)) |=> $stable(cnt_q));
  // R7
  park_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (cnt_q == '0));
  // R7
  park_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && trig_m && tick_i && cnt_q == LAST_RAMP) |=> hold_q);
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig_m && !hold_q && tick_i && cnt_q == CNT_TOP) |=> (cnt_q == '0));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_q && trig_m && rel_i) |=> !hold_q);
  // R10
  free_release_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !trig_m) |=> !hold_q);
  // R11
  late_park_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && trig_m && in_blank) |=> hold_q);
endmodule

// File: rtl/ramp_code_gate.sv
module ramp_code_gate #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned RAMP_LEN = 4000
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] code_o,
  output logic             blank_o
);
  localparam logic [CNT_W-1:0] BLANK_START = CNT_W'(RAMP_LEN);

  assign blank_o = hold_i | (cnt_i >= BLANK_START);

  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign code_o[b] = cnt_i[b] & ~blank_o;
  end
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
  import ramp_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = RS_CNT_W,
  parameter int unsigned RAMP_LEN    = RS_RAMP_LEN,
  parameter int unsigned SYNC_STAGES = RS_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             trig_mode,
  input  logic             trig_in,
  output logic [CNT_W-1:0] dac_code,
  output logic             blank
);
  localparam logic [CNT_W-1:0] BLANK_START = CNT_W'(RAMP_LEN);

  logic             rel_edge;
  logic [CNT_W-1:0] cnt;
  logic             hold;

  ramp_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .trig_in (trig_in),
    .edge_o  (rel_edge)
  );

  ramp_count_core #(.CNT_W(CNT_W), .RAMP_LEN(RAMP_LEN)) core_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_en),
    .mode_i (trig_mode),
    .rel_i  (rel_edge),
    .cnt_o  (cnt),
    .hold_o (hold)
  );

  ramp_code_gate #(.CNT_W(CNT_W), .RAMP_LEN(RAMP_LEN)) gate_i (
    .cnt_i   (cnt),
    .hold_i  (hold),
    .code_o  (dac_code),
    .blank_o (blank)
  );

  // R2
  ramp_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && cnt < BLANK_START) |-> (dac_code == cnt && !blank));
  // R3
  window_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= BLANK_START) |-> (dac_code == '0 && blank));
  // R4
  park_blank_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> (blank && dac_code == '0));
endmodule

// File: tb/ramp_seq_tb.sv
module ramp_seq_tb_top;
  localparam int RL  = 4000;
  localparam int MOD = 4096;

  logic        clk = 1'b0;
  logic        rst, tick_en, trig_mode, trig_in;
  logic [11:0] dac_code;
  logic        blank;

  int vec_n = 0;
  int bad_n = 0;
  bit done  = 1'b0;

  int m_cnt = 0;
  bit m_hold = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

  always #4 clk = ~clk;

  ramp_seq dut_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .trig_mode (trig_mode),
    .trig_in   (trig_in),
    .dac_code  (dac_code),
    .blank     (blank)
  );

  function automatic int exp_code(int c, bit h);
    return (h || c >= RL) ? 0 : c;
  endfunction

  function automatic int exp_blank(int c, bit h);
    return (h || c >= RL) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    vec_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(bit r, bit t, bit m, bit g);
    bit edge_v;
    edge_v = m_s2 && !m_s3;
    if (r) begin
      m_cnt = 0; m_hold = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      if (m_hold) begin
        m_cnt = 0;
        if (!m || edge_v) m_hold = 0;
      end else if (m && (m_cnt >= RL || (t && m_cnt == RL - 1))) begin
        m_hold = 1; m_cnt = 0;
      end else if (t) begin
        m_cnt = (m_cnt + 1) % MOD;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = g;
    end
  endtask

  task automatic cyc(bit r, bit t, bit m, bit g);
    string tag;
    rst = r; tick_en = t; trig_mode = m; trig_in = g;
    @(posedge clk);
    model_step(r, t, m, g);
    @(negedge clk);
    tag = m_hold ? "R7" : ((m_cnt >= RL) ? "R3" : "R2");
    check(tag, int'(dac_code), exp_code(m_cnt, m_hold));
    check("R4", int'(blank), exp_blank(m_cnt, m_hold));
  endtask

  initial begin
    int blanks;
    int c0;
    bit mode_r;
    rst = 1'b1; tick_en = 1'b0; trig_mode = 1'b0; trig_in = 1'b0;
    void'($urandom(32'd20250611));
    @(negedge clk);

    // R1: reset state
    repeat (3) cyc(1, 1, 0, 0);
    check("R1", int'(dac_code), 0);
    check("R1", int'(blank), 0);

    // R3 / R5: one full free-running period
    blanks = 0;
    for (int i = 0; i < MOD; i++) begin
      cyc(0, 1, 0, 0);
      if (blank) blanks++;
      if (i == RL - 2) check("R2", int'(dac_code), RL - 1);
      if (i == RL - 1) check("R4", int'(blank), 1);
    end
    check("R3", blanks, 96);
    check("R5", int'(dac_code), 0);
    check("R5", int'(blank), 0);

    // R6: no tick, no movement
    repeat (10) cyc(0, 1, 0, 0);
    repeat (5) cyc(0, 0, 0, 0);
    check("R6", int'(dac_code), 10);

    // random tick gating
    for (int i = 0; i < 400; i++) cyc(0, 1'($urandom % 2), 0, 0);

    // R9: trigger pulses during a ramp in triggered mode are ignored
    cyc(0, 0, 1, 0);
    c0 = int'(dac_code);
    repeat (4) cyc(0, 1, 1, 1);
    repeat (2) cyc(0, 1, 1, 0);
    check("R9", int'(dac_code), c0 + 6);

    // R7: park at end of ramp
    for (int i = 0; i < 5000 && !m_hold; i++) cyc(0, 1, 1, 0);
    check("R7", int'(m_hold), 1);
    repeat (50) cyc(0, 1, 1, 0);
    check("R7", int'(blank), 1);
    check("R7", int'(dac_code), 0);

    // R8: release latency and restart from zero
    cyc(0, 0, 1, 1);
    check("R8", int'(blank), 1);
    cyc(0, 0, 1, 1);
    check("R8", int'(blank), 1);
    cyc(0, 0, 1, 0);
    check("R8", int'(blank), 0);
    cyc(0, 1, 1, 0);
    check("R8", int'(dac_code), 1);

    // R10: leaving triggered mode while parked
    for (int i = 0; i < 5000 && !m_hold; i++) cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 0);
    check("R10", int'(blank), 0);
    cyc(0, 1, 0, 0);
    check("R10", int'(dac_code), 1);

    // R11: entering triggered mode inside the blanking window
    for (int i = 0; i < 5000 && m_cnt != 4050; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    check("R11", int'(blank), 1);
    repeat (10) cyc(0, 1, 1, 0);
    check("R11", int'(dac_code), 0);
    check("R11", int'(blank), 1);
    cyc(0, 0, 0, 0);

    // constrained random mix
    mode_r = 1'b0;
    for (int i = 0; i < 30000; i++) begin
      if ($urandom % 3000 == 0) mode_r = ~mode_r;
      cyc(0, 1'(($urandom % 4) != 0), mode_r, 1'(($urandom % 64) == 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec_n++;
      bad_n++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
    end
  end
endmodule